// File: doc/BRIEF.md
# Dual-Port Strided Byte NVRAM

This block models an 8 KiB byte-wide nonvolatile-style memory that two requesters share. The bus port exposes the array with one byte every 16 address bytes. It decodes the byte index from the address bits above that stride and wraps around the array, so it never sees an out-of-range access. The direct port takes a plain byte index and checks it against the array size. Out-of-range reads answer with all ones, and out-of-range writes are dropped.

Both ports use a simple valid/write/address/data request. A read answers one cycle later with a read-valid strobe. A write produces no response. Only the low byte of write data is stored, and read data comes back zero-extended to 32 bits. Storage is held as 32-bit words with byte lanes, and it clears to zero on reset.

Each port has a response state machine with three states:
- `RSP_IDLE`: no answer this cycle.
- `RSP_DATA`: a stored byte is returned.
- `RSP_FAULT`: a direct read was out of range, and all ones are returned.

Transitions:
- From any state, a read request moves the machine to `RSP_DATA`, or to `RSP_FAULT` for an out-of-range direct read.
- From any state, a cycle with no read request returns it to `RSP_IDLE`.

Top module: `nvram_dual_port`

## Requirements
- R1: The array holds 8192 bytes, index 0 to 0x1FFF. A byte written at any in-range index, including 0x1FFF, reads back unchanged.
- R2: The bus port byte index is bus address bits [16:4]. Address bits [3:0] do not select a byte.
- R3: Bus address bits [31:17] are ignored, so bus addresses wrap around the array.
- R4: A direct read with index 0x2000 or above returns 0xFFFFFFFF with the read-valid strobe.
- R5: A direct write with index 0x2000 or above changes no byte.
- R6: Only write data bits [7:0] are stored. Read data of an in-range byte has bits [31:8] equal to zero on both ports.
- R7: Read-valid rises exactly one cycle after a read request and only then. Writes and idle cycles give no read-valid.
- R8: When both ports write the same byte in one cycle, the bus value is kept. Writes to different bytes in one cycle both take effect.
- R9: A read of a byte being written in the same cycle returns the old value.
- R10: After reset every byte reads as zero and no read-valid is asserted.
- R11: Both ports reach the same storage: bus address 16*i and direct index i name the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the array |
| bus_req | input | 1 | Bus port request |
| bus_we | input | 1 | Bus port write (1) or read (0) |
| bus_addr | input | 32 | Bus byte address, stride 16 |
| bus_wdata | input | 32 | Bus write data, low byte used |
| bus_rvalid | output | 1 | Bus read data valid |
| bus_rdata | output | 32 | Bus read data, zero-extended |
| dir_req | input | 1 | Direct port request |
| dir_we | input | 1 | Direct port write (1) or read (0) |
| dir_idx | input | 32 | Direct byte index, bounds-checked |
| dir_wdata | input | 32 | Direct write data, low byte used |
| dir_rvalid | output | 1 | Direct read data valid |
| dir_rdata | output | 32 | Direct read data or all ones |

## Verification
Two kinds of cycle make both ports touch storage together. In the first, both ports write at once. The bench drives both to one byte and checks that the bus value survives, then drives neighbouring bytes of one storage word and checks that both survive. In the second, one port reads a byte while the other writes it. The bench checks that the read returns the old value and that a later read returns the new one.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

    parameter int unsigned NV_IDX_W    = 13;
    parameter int unsigned NV_ADDR_W   = 32;
    parameter int unsigned NV_DATA_W   = 32;
    parameter int unsigned NV_STRIDE_LG = 4;
    parameter int unsigned NV_LANES    = 4;

    typedef logic [7:0] nv_byte_t;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/nvram_bus_dec.sv
module nvram_bus_dec
    import nvram_pkg::*;
#(
    parameter int unsigned ADDR_W    = NV_ADDR_W,
    parameter int unsigned DATA_W    = NV_DATA_W,
    parameter int unsigned IDX_W     = NV_IDX_W,
    parameter int unsigned STRIDE_LG = NV_STRIDE_LG
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_en,
    output logic              rd_en,
    output logic [IDX_W-1:0]  idx,
    output nv_byte_t          wbyte
);
    localparam int unsigned TOP_BIT = STRIDE_LG + IDX_W;

    // stride bits below and wrap bits above the index are dropped
    logic unused_bits;
    assign unused_bits = ^{addr[ADDR_W-1:TOP_BIT], addr[STRIDE_LG-1:0], wdata[DATA_W-1:8]};

    assign idx   = addr[STRIDE_LG +: IDX_W];
    assign wbyte = wdata[7:0];
    assign wr_en = req && we;
    assign rd_en = req && !we;
endmodule

// File: rtl/nvram_dir_dec.sv
module nvram_dir_dec
    import nvram_pkg::*;
#(
    parameter int unsigned ADDR_W = NV_ADDR_W,
    parameter int unsigned DATA_W = NV_DATA_W,
    parameter int unsigned IDX_W  = NV_IDX_W
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] index,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_en,
    output logic              rd_en,
    output logic              fault,
    output logic [IDX_W-1:0]  idx,
    output nv_byte_t          wbyte
);
    logic in_range;
    logic unused_bits;

    assign unused_bits = ^wdata[DATA_W-1:8];
    assign in_range = (index[ADDR_W-1:IDX_W] == '0);
    assign idx      = index[IDX_W-1:0];
    assign wbyte    = wdata[7:0];
    assign wr_en    = req && we && in_range;
    assign rd_en    = req && !we;
    assign fault    = !in_range;
endmodule

// File: rtl/nvram_store.sv
module nvram_store
    import nvram_pkg::*;
#(
    parameter int unsigned IDX_W = NV_IDX_W,
    parameter int unsigned LANES = NV_LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_we,
    input  logic [IDX_W-1:0] a_idx,
    input  nv_byte_t         a_data,
    input  logic             b_we,
    input  logic [IDX_W-1:0] b_idx,
    input  nv_byte_t         b_data,
    output nv_byte_t         a_rbyte,
    output nv_byte_t         b_rbyte
);
    localparam int unsigned LANE_W = $clog2(LANES);
    localparam int unsigned WORD_W = IDX_W - LANE_W;
    localparam int unsigned DEPTH  = 1 << WORD_W;
    localparam int unsigned WBITS  = 8 * LANES;

    logic [WBITS-1:0] mem [DEPTH];

    logic [WORD_W-1:0] a_word, b_word;
    logic [LANE_W-1:0] a_lane, b_lane;

    assign a_word = a_idx[IDX_W-1:LANE_W];
    assign a_lane = a_idx[LANE_W-1:0];
    assign b_word = b_idx[IDX_W-1:LANE_W];
    assign b_lane = b_idx[LANE_W-1:0];

    // port b first, port a last: port a (bus) wins a same-byte collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int unsigned w = 0; w < DEPTH; w++) begin
                mem[WORD_W'(w)] <= '0;
            end
        end else begin
            for (int unsigned l = 0; l < LANES; l++) begin
                if (b_we && (b_lane == LANE_W'(l))) mem[b_word][l*8 +: 8] <= b_data;
                if (a_we && (a_lane == LANE_W'(l))) mem[a_word][l*8 +: 8] <= a_data;
            end
        end
    end

    // reads see the array before this cycle's writes
    assign a_rbyte = mem[a_word][a_lane*8 +: 8];
    assign b_rbyte = mem[b_word][b_lane*8 +: 8];

    // collision bookkeeping for the priority check
    logic             coll_q;
    logic [IDX_W-1:0] coll_idx_q;
    nv_byte_t         coll_data_q;
    nv_byte_t         coll_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coll_q      <= 1'b0;
            coll_idx_q  <= '0;
            coll_data_q <= '0;
        end else begin
            coll_q      <= a_we && b_we && (a_idx == b_idx);
            coll_idx_q  <= a_idx;
            coll_data_q <= a_data;
        end
    end

    assign coll_seen = mem[coll_idx_q[IDX_W-1:LANE_W]][coll_idx_q[LANE_W-1:0]*8 +: 8];

    assert_bus_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        coll_q |-> (coll_seen == coll_data_q));
endmodule

// File: rtl/nvram_rsp.sv
module nvram_rsp
    import nvram_pkg::*;
#(
    parameter int unsigned DATA_W = NV_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              fault,
    input  nv_byte_t          rbyte,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    rsp_state_e state_q, state_d;
    nv_byte_t   byte_q;

    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_DATA, RSP_FAULT: begin
                if (rd_req) state_d = fault ? RSP_FAULT : RSP_DATA;
                else        state_d = RSP_IDLE;
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req && !fault) byte_q <= rbyte;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            RSP_IDLE:  begin rvalid = 1'b0; rdata = '0; end
            RSP_DATA:  begin rvalid = 1'b1; rdata = {{(DATA_W-8){1'b0}}, byte_q}; end
            RSP_FAULT: begin rvalid = 1'b1; rdata = '1; end
            default:   begin rvalid = 1'b0; rdata = '0; end
        endcase
    end

    assert_state_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {RSP_IDLE, RSP_DATA, RSP_FAULT});
endmodule

// File: rtl/nvram_dual_port.sv
module nvram_dual_port
    import nvram_pkg::*;
#(
    parameter int unsigned ADDR_W    = NV_ADDR_W,
    parameter int unsigned DATA_W    = NV_DATA_W,
    parameter int unsigned IDX_W     = NV_IDX_W,
    parameter int unsigned STRIDE_LG = NV_STRIDE_LG,
    parameter int unsigned LANES     = NV_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dir_req,
    input  logic              dir_we,
    input  logic [ADDR_W-1:0] dir_idx,
    input  logic [DATA_W-1:0] dir_wdata,
    output logic              dir_rvalid,
    output logic [DATA_W-1:0] dir_rdata
);
    localparam logic [ADDR_W-1:0] NBYTES = ADDR_W'(1) << IDX_W;

    logic             b_wr, b_rd, d_wr, d_rd, d_fault;
    logic [IDX_W-1:0] b_idx, d_idx;
    nv_byte_t         b_wbyte, d_wbyte, b_rbyte, d_rbyte;

    nvram_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .STRIDE_LG(STRIDE_LG)) u_bus_dec (
        .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .wr_en(b_wr), .rd_en(b_rd), .idx(b_idx), .wbyte(b_wbyte)
    );

    nvram_dir_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dir_dec (
        .req(dir_req), .we(dir_we), .index(dir_idx), .wdata(dir_wdata),
        .wr_en(d_wr), .rd_en(d_rd), .fault(d_fault), .idx(d_idx), .wbyte(d_wbyte)
    );

    nvram_store #(.IDX_W(IDX_W), .LANES(LANES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_we(b_wr), .a_idx(b_idx), .a_data(b_wbyte),
        .b_we(d_wr), .b_idx(d_idx), .b_data(d_wbyte),
        .a_rbyte(b_rbyte), .b_rbyte(d_rbyte)
    );

    nvram_rsp #(.DATA_W(DATA_W)) u_bus_rsp (
        .clk(clk), .rst_n(rst_n), .rd_req(b_rd), .fault(1'b0), .rbyte(b_rbyte),
        .rvalid(bus_rvalid), .rdata(bus_rdata)
    );

    nvram_rsp #(.DATA_W(DATA_W)) u_dir_rsp (
        .clk(clk), .rst_n(rst_n), .rd_req(d_rd), .fault(d_fault), .rbyte(d_rbyte),
        .rvalid(dir_rvalid), .rdata(dir_rdata)
    );

    // one cycle of history is valid once this is set
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_bus_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (bus_rvalid == $past(bus_req && !bus_we)));

    assert_dir_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (dir_rvalid == $past(dir_req && !dir_we)));

    assert_oor_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(dir_req && !dir_we && (dir_idx >= NBYTES))) |-> (dir_rvalid && (dir_rdata == '1)));

    assert_bus_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[DATA_W-1:8] == '0));

    assert_dir_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(dir_req && !dir_we && (dir_idx < NBYTES))) |-> (dir_rdata[DATA_W-1:8] == '0));

    assert_oor_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_req && dir_we && (dir_idx >= NBYTES)) |-> !d_wr);
endmodule

// File: tb/test_nvram_dual_port.sv
module test_nvram_dual_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_we = 0, dir_req = 0, dir_we = 0;
    logic [31:0] bus_addr = 0, bus_wdata = 0, dir_idx = 0, dir_wdata = 0;
    logic        bus_rvalid, dir_rvalid;
    logic [31:0] bus_rdata, dir_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic        s_bv, s_dv;
    logic [31:0] s_bd, s_dd;

    always #2.5 clk = ~clk;

    nvram_dual_port i_nvram_dual_port (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .dir_req(dir_req), .dir_we(dir_we), .dir_idx(dir_idx), .dir_wdata(dir_wdata),
        .dir_rvalid(dir_rvalid), .dir_rdata(dir_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive both ports, sample outputs just after the edge
    task automatic cyc(input logic breq, input logic bwe, input logic [31:0] ba, input logic [31:0] bd,
                       input logic dreq, input logic dwe, input logic [31:0] di, input logic [31:0] dd);
        @(negedge clk);
        bus_req = breq; bus_we = bwe; bus_addr = ba; bus_wdata = bd;
        dir_req = dreq; dir_we = dwe; dir_idx = di; dir_wdata = dd;
        @(posedge clk);
        #1;
        s_bv = bus_rvalid; s_bd = bus_rdata; s_dv = dir_rvalid; s_dd = dir_rdata;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic bwr(input logic [31:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 0, 0, 0, 0);
        check("R7 no rvalid on bus write", {31'd0, s_bv}, 32'd0);
    endtask

    task automatic dwr(input logic [31:0] i, input logic [31:0] d);
        cyc(0, 0, 0, 0, 1, 1, i, d);
        check("R7 no rvalid on direct write", {31'd0, s_dv}, 32'd0);
    endtask

    task automatic brd(input string req, input logic [31:0] a, input logic [31:0] exp);
        cyc(1, 0, a, 0, 0, 0, 0, 0);
        check({req, " bus rvalid"}, {31'd0, s_bv}, 32'd1);
        check(req, s_bd, exp);
    endtask

    task automatic drd(input string req, input logic [31:0] i, input logic [31:0] exp);
        cyc(0, 0, 0, 0, 1, 0, i, 0);
        check({req, " dir rvalid"}, {31'd0, s_dv}, 32'd1);
        check(req, s_dd, exp);
    endtask

    task automatic t_reset();
        check("R10 bus rvalid low after reset", {31'd0, bus_rvalid}, 32'd0);
        check("R10 dir rvalid low after reset", {31'd0, dir_rvalid}, 32'd0);
        drd("R10 byte 0 zero", 32'h0, 32'h0);
        drd("R10 byte 0x1FFF zero", 32'h1FFF, 32'h0);
        brd("R10 bus last byte zero", 32'h1FFF0, 32'h0);
    endtask

    task automatic t_shared();
        bwr(32'h30, 32'hA5);
        drd("R11 bus write seen on direct", 32'd3, 32'hA5);
        dwr(32'd5, 32'h3C);
        brd("R11 direct write seen on bus", 32'h50, 32'h3C);
        brd("R2 low address bits ignored", 32'h5F, 32'h3C);
        idle();
        check("R7 rvalid drops after read", {31'd0, s_bv}, 32'd0);
    endtask

    task automatic t_wrap();
        bwr(32'h0002_0070, 32'h11);
        drd("R3 high bits wrap on write", 32'd7, 32'h11);
        brd("R3 high bits wrap on read", 32'hFFFE_0070, 32'h11);
    endtask

    task automatic t_bytes();
        bwr(32'h90, 32'hDEADBE77);
        drd("R6 direct sees low byte only", 32'd9, 32'h77);
        brd("R6 bus read zero-extended", 32'h90, 32'h77);
        dwr(32'd10, 32'h123456AB);
        brd("R6 direct write low byte only", 32'hA0, 32'hAB);
    endtask

    task automatic t_bounds();
        drd("R4 read at 0x2000 is all ones", 32'h2000, 32'hFFFF_FFFF);
        drd("R4 read at max index is all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        dwr(32'h2000, 32'h99);
        dwr(32'h2003, 32'h99);
        drd("R5 write 0x2000 did not alias 0", 32'd0, 32'h0);
        drd("R5 write 0x2003 did not alias 3", 32'd3, 32'hA5);
        dwr(32'h1FFF, 32'hEE);
        brd("R1 top byte stored", 32'h1FFF0, 32'hEE);
    endtask

    task automatic t_collide();
        cyc(1, 1, 32'hC0, 32'h22, 1, 1, 32'd12, 32'h33);
        drd("R8 bus wins same byte", 32'd12, 32'h22);
        cyc(1, 1, 32'h100, 32'h44, 1, 1, 32'd17, 32'h55);
        drd("R8 bus byte in shared word", 32'd16, 32'h44);
        drd("R8 direct byte in shared word", 32'd17, 32'h55);
    endtask

    task automatic t_rbw();
        dwr(32'd20, 32'h66);
        cyc(1, 1, 32'h140, 32'h77, 1, 0, 32'd20, 0);
        check("R9 read during write rvalid", {31'd0, s_dv}, 32'd1);
        check("R9 read during write old value", s_dd, 32'h66);
        drd("R9 new value after write", 32'd20, 32'h77);
        cyc(1, 0, 32'h140, 0, 1, 1, 32'd20, 32'h88);
        check("R9 bus read during direct write old value", s_bd, 32'h77);
        brd("R9 bus sees direct value after", 32'h140, 32'h88);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_shared();
        t_wrap();
        t_bytes();
        t_bounds();
        t_collide();
        t_rbw();
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule